// File: doc/BRIEF.md
# Agent Operating Mode Controller

This block holds the operating mode of a small set of switch agents and the clock gating that belongs to them. Software writes a 2-bit target mode for an agent. The agent's reached mode moves to that target only after a fixed number of cycles in which the agent's clock is running. Software polls a status register until the reached mode equals the target.

Clock gating has two levels. A global enable and one enable per agent sit together in one register. A separate write-one-to-clear register drops individual agent enables. A software reset bit forces every agent back to the reset mode for as long as it is held. After the bit is released, software steps each agent forward again, normally to the disable mode first.

The block also contains a clearing engine for an external table RAM of `INIT_DEPTH` entries. Once started, it issues one clear strobe per cycle with an incrementing address. When the sweep is finished it raises a ready flag.

All control goes through a simple 32-bit register port. A read returns its data one cycle after the read strobe.

Top module: `agent_mode_ctrl`

Register offsets:
- 0x00: software reset. Bit 0 is the reset bit.
- 0x04: clock enable. Bit 16 is the global enable. Bits [N-1:0] are the per-agent enables.
- 0x08: clock disable. Write-one-to-clear; reads as 0.
- 0x0C: clear engine. Bit 0 is busy, bit 1 is ready.
- 0x20 + 4·i: target mode of agent i.
- 0x40 + 4·i: reached mode of agent i.

Mode codes: 0 = reset, 1 = disable, 2 = config, 3 = operation.

## Requirements
- R1: After `rst`, every agent's reached mode and target mode are 0 (reset), every agent clock enable and the global enable are 0, the clear engine is neither busy nor ready, and `bus_rdata_o` is 0.
- R2: A write to 0x20+4·i stores bits [1:0] as agent i's target mode, using the codes 0 reset, 1 disable, 2 config and 3 operation. The target reads back at 0x20+4·i, and the reached mode reads at 0x40+4·i in bits [1:0].
- R3: After a target write, the reached mode of that agent keeps its old value for TRANS_CYCLES−1 clock-enabled cycles. It takes the new value on the TRANS_CYCLES-th such cycle (8 by default), and it only ever changes to the current target or to reset.
- R4: No clock edge on which the global enable (bit 16 of 0x04) or the agent's own enable is 0 advances that agent's transition. The cycles already counted are kept and resume when the clock returns.
- R5: Writing a 1 to bit i of 0x08 clears agent i's enable. Other agents and the global enable keep their values, and 0x08 reads as 0.
- R6: `agent_clk_en_o[i]` is 1 exactly when both the global enable and agent i's enable are set.
- R7: A new target write while a transition is in progress restarts the cycle count from zero.
- R8: While bit 0 of 0x00 is 1, every agent's target and reached mode are held at reset and target writes are ignored. Clearing the bit leaves the agents in reset until new targets are written. The clock enables are not affected.
- R9: Writing 1 to bit 0 of 0x0C starts a sweep. `clr_we_o` is high for INIT_DEPTH consecutive cycles with `clr_addr_o` counting 0 up to INIT_DEPTH−1. Then 0x0C reads busy (bit 0) clear and ready (bit 1) set.
- R10: Writing 1 to bit 0 of 0x0C again, including during a sweep, clears ready and restarts the sweep from address 0. Writing 0 there has no effect.
- R11: Read data appears on `bus_rdata_o` the cycle after `bus_rd_i` and holds until the next read. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| agent_mode_o | output | 2·N_AGENTS | Reached mode per agent, agent i in bits [2i+1:2i] |
| agent_clk_en_o | output | N_AGENTS | Effective clock enable per agent |
| clr_we_o | output | 1 | Clear strobe for the external table RAM |
| clr_addr_o | output | $clog2(INIT_DEPTH) | Address being cleared |

## Verification
A transition counter that is wrong by one shows on `agent_mode_o` in the very cycle the reached mode should have changed. The bench samples that edge and the one just before it, so an off-by-one is caught at once. A counter that runs while gated, or fails to restart on a new target, moves the mode at the wrong edge of a window of known length. A sweep address that skips, or a ready flag that rises early, is seen on `clr_addr_o` within one cycle or on the status read that follows the sweep.

// File: rtl/agmc_pkg.sv
package agmc_pkg;

    typedef enum logic [1:0] {
        MODE_RESET   = 2'd0,
        MODE_DISABLE = 2'd1,
        MODE_CONFIG  = 2'd2,
        MODE_OPER    = 2'd3
    } agent_mode_e;

    localparam logic [7:0] OFS_SOFTRST = 8'h00;
    localparam logic [7:0] OFS_CLKEN   = 8'h04;
    localparam logic [7:0] OFS_CLKDIS  = 8'h08;
    localparam logic [7:0] OFS_INIT    = 8'h0C;
    localparam logic [7:0] REQ_BASE    = 8'h20;
    localparam logic [7:0] STAT_BASE   = 8'h40;
    localparam int         CLK_GLB_BIT = 16;

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [7:0]  addr;
        logic [31:0] wdata;
    } bus_req_t;

    function automatic logic [7:0] agent_ofs(logic [7:0] base, int unsigned idx);
        return base + 8'(idx * 4);
    endfunction

endpackage

// File: rtl/agmc_agent_fsm.sv
module agmc_agent_fsm
    import agmc_pkg::*;
#(
    parameter int TRANS_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hold_rst,
    input  logic        clk_ok,
    input  logic        req_we,
    input  agent_mode_e req_mode,
    output agent_mode_e req_q,
    output agent_mode_e stat_q
);
    localparam int CW = $clog2(TRANS_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(TRANS_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || hold_rst) begin
            req_q  <= MODE_RESET;
            stat_q <= MODE_RESET;
            cnt_q  <= '0;
        end else if (req_we) begin
            req_q <= req_mode;
            cnt_q <= '0;
        end else if (clk_ok && (req_q != stat_q)) begin
            if (cnt_q == LAST) begin
                stat_q <= req_q;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

endmodule

// File: rtl/agmc_init_sweep.sv
module agmc_init_sweep #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          busy,
    output logic          ready,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            ready <= 1'b0;
            addr  <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            ready <= 1'b0;
            addr  <= '0;
        end else if (busy) begin
            if (addr == LAST) begin
                busy  <= 1'b0;
                ready <= 1'b1;
                addr  <= '0;
            end else begin
                addr <= addr + AW'(1);
            end
        end
    end

endmodule

// File: rtl/agent_mode_ctrl.sv
module agent_mode_ctrl
    import agmc_pkg::*;
#(
    parameter int N_AGENTS     = 4,
    parameter int TRANS_CYCLES = 8,
    parameter int INIT_DEPTH   = 64,
    localparam int CLR_AW      = $clog2(INIT_DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr_i,
    input  logic                  bus_rd_i,
    input  logic [7:0]            bus_addr_i,
    input  logic [31:0]           bus_wdata_i,
    output logic [31:0]           bus_rdata_o,
    output logic [2*N_AGENTS-1:0] agent_mode_o,
    output logic [N_AGENTS-1:0]   agent_clk_en_o,
    output logic                  clr_we_o,
    output logic [CLR_AW-1:0]     clr_addr_o
);
    bus_req_t bq;
    assign bq = '{wr: bus_wr_i, rd: bus_rd_i, addr: bus_addr_i, wdata: bus_wdata_i};

    logic unused_bus;
    assign unused_bus = ^bus_wdata_i;

    logic                soft_rst_q;
    logic                clk_glb_q;
    logic [N_AGENTS-1:0] clk_agent_q;
    logic [N_AGENTS-1:0] clk_drop;
    logic                wr_softrst, wr_clken, wr_clkdis, wr_init;
    logic                init_start, init_busy, init_ready;

    assign wr_softrst = bq.wr && (bq.addr == OFS_SOFTRST);
    assign wr_clken   = bq.wr && (bq.addr == OFS_CLKEN);
    assign wr_clkdis  = bq.wr && (bq.addr == OFS_CLKDIS);
    assign wr_init    = bq.wr && (bq.addr == OFS_INIT);
    assign init_start = wr_init && bq.wdata[0];
    assign clk_drop   = {N_AGENTS{wr_clkdis}} & bq.wdata[N_AGENTS-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            soft_rst_q  <= 1'b0;
            clk_glb_q   <= 1'b0;
            clk_agent_q <= '0;
        end else begin
            if (wr_softrst) soft_rst_q <= bq.wdata[0];
            if (wr_clken) begin
                clk_glb_q   <= bq.wdata[CLK_GLB_BIT];
                clk_agent_q <= bq.wdata[N_AGENTS-1:0];
            end else begin
                clk_agent_q <= clk_agent_q & ~clk_drop;
            end
        end
    end

    agent_mode_e         req_q  [N_AGENTS];
    agent_mode_e         stat_q [N_AGENTS];
    logic [2*N_AGENTS-1:0] req_flat;

    for (genvar i = 0; i < N_AGENTS; i++) begin : g_agent
        logic req_we;
        assign req_we            = bq.wr && (bq.addr == agent_ofs(REQ_BASE, i));
        assign agent_clk_en_o[i] = clk_glb_q & clk_agent_q[i];

        agmc_agent_fsm #(.TRANS_CYCLES(TRANS_CYCLES)) u_fsm (
            .clk      (clk),
            .rst      (rst),
            .hold_rst (soft_rst_q),
            .clk_ok   (agent_clk_en_o[i]),
            .req_we   (req_we),
            .req_mode (agent_mode_e'(bq.wdata[1:0])),
            .req_q    (req_q[i]),
            .stat_q   (stat_q[i])
        );

        assign agent_mode_o[2*i +: 2] = stat_q[i];
        assign req_flat[2*i +: 2]     = req_q[i];
    end

    agmc_init_sweep #(.DEPTH(INIT_DEPTH)) u_sweep (
        .clk   (clk),
        .rst   (rst),
        .start (init_start),
        .busy  (init_busy),
        .ready (init_ready),
        .addr  (clr_addr_o)
    );
    assign clr_we_o = init_busy;

    logic [31:0] rd_word;
    always_comb begin
        rd_word = '0;
        if (bq.addr == OFS_SOFTRST) rd_word[0] = soft_rst_q;
        if (bq.addr == OFS_CLKEN) begin
            rd_word[CLK_GLB_BIT]    = clk_glb_q;
            rd_word[N_AGENTS-1:0]   = clk_agent_q;
        end
        if (bq.addr == OFS_INIT) rd_word[1:0] = {init_ready, init_busy};
        for (int i = 0; i < N_AGENTS; i++) begin
            if (bq.addr == agent_ofs(REQ_BASE, i))  rd_word[1:0] = req_q[i];
            if (bq.addr == agent_ofs(STAT_BASE, i)) rd_word[1:0] = stat_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        bus_rdata_o <= '0;
        else if (bq.rd) bus_rdata_o <= rd_word;
    end

endmodule

// File: rtl/agent_mode_ctrl_chk.sv
module agent_mode_ctrl_chk #(
    parameter int N_AGENTS   = 4,
    parameter int INIT_DEPTH = 64,
    localparam int CLR_AW    = $clog2(INIT_DEPTH)
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  soft_rst,
    input logic                  init_start,
    input logic                  init_ready,
    input logic [N_AGENTS-1:0]   clk_drop,
    input logic [2*N_AGENTS-1:0] req_flat,
    input logic [2*N_AGENTS-1:0] agent_mode_o,
    input logic [N_AGENTS-1:0]   agent_clk_en_o,
    input logic                  clr_we_o,
    input logic [CLR_AW-1:0]     clr_addr_o
);
    localparam logic [CLR_AW-1:0] LAST = CLR_AW'(INIT_DEPTH - 1);

    for (genvar i = 0; i < N_AGENTS; i++) begin : g_chk
        // R4
        gated_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!agent_clk_en_o[i] && !soft_rst) |=> $stable(agent_mode_o[2*i +: 2]));

        // R3
        mode_target_chk: assert property (@(posedge clk) disable iff (rst)
            !$stable(agent_mode_o[2*i +: 2]) |->
                ((agent_mode_o[2*i +: 2] == $past(req_flat[2*i +: 2])) || $past(soft_rst)));

        // R5
        clk_drop_chk: assert property (@(posedge clk) disable iff (rst)
            clk_drop[i] |=> !agent_clk_en_o[i]);
    end

    // R9
    sweep_step_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_we_o && (clr_addr_o != LAST) && !init_start) |=>
            (clr_we_o && (clr_addr_o == $past(clr_addr_o) + CLR_AW'(1))));

    // R9
    sweep_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(init_ready) |-> ($past(clr_we_o) && ($past(clr_addr_o) == LAST)));

    // R10
    sweep_restart_chk: assert property (@(posedge clk) disable iff (rst)
        init_start |=> (clr_we_o && (clr_addr_o == '0) && !init_ready));

endmodule

bind agent_mode_ctrl agent_mode_ctrl_chk #(
    .N_AGENTS   (N_AGENTS),
    .INIT_DEPTH (INIT_DEPTH)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .soft_rst       (soft_rst_q),
    .init_start     (init_start),
    .init_ready     (init_ready),
    .clk_drop       (clk_drop),
    .req_flat       (req_flat),
    .agent_mode_o   (agent_mode_o),
    .agent_clk_en_o (agent_clk_en_o),
    .clr_we_o       (clr_we_o),
    .clr_addr_o     (clr_addr_o)
);

// File: tb/tb_agent_mode_ctrl.sv
module tb_agent_mode_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;
    localparam int TRANS      = 8;
    localparam int DEPTH      = 64;
    localparam int AW         = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [2*N-1:0] agent_mode;
    logic [N-1:0]  agent_clk_en;
    logic          clr_we;
    logic [AW-1:0] clr_addr;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;
    logic [1:0] exp_mode [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    agent_mode_ctrl #(.N_AGENTS(N), .TRANS_CYCLES(TRANS), .INIT_DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .agent_mode_o(agent_mode), .agent_clk_en_o(agent_clk_en),
        .clr_we_o(clr_we), .clr_addr_o(clr_addr)
    );

    function automatic logic [7:0] req_ofs(int i);  return 8'h20 + 8'(4*i); endfunction
    function automatic logic [7:0] stat_ofs(int i); return 8'h40 + 8'(4*i); endfunction
    function automatic logic [31:0] clken_word(bit glb, logic [N-1:0] en);
        return (32'(glb) << 16) | 32'(en);
    endfunction
    function automatic logic [2*N-1:0] packed_exp();
        logic [2*N-1:0] v;
        for (int i = 0; i < N; i++) v[2*i +: 2] = exp_mode[i];
        return v;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    // write a target and check the exact edge at which the reached mode moves
    task automatic timed_change(int i, logic [1:0] nm, string tag);
        logic [1:0] old = exp_mode[i];
        bus_write(req_ofs(i), 32'(nm));
        repeat (TRANS-1) @(negedge clk);
        check({tag, " before"}, 32'(agent_mode[2*i +: 2]), 32'(old));
        @(negedge clk);
        check({tag, " after"}, 32'(agent_mode[2*i +: 2]), 32'(nm));
        exp_mode[i] = nm;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_err++;
            $display("FAIL WDOG actual=timeout expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd;
        for (int i = 0; i < N; i++) exp_mode[i] = 2'd0;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        // R1 reset state at the ports
        check("R1 mode", 32'(agent_mode), 32'd0);
        check("R1 clken", 32'(agent_clk_en), 32'd0);
        check("R1 clrwe", 32'(clr_we), 32'd0);
        check("R1 rdata", bus_rdata, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        bus_read(8'h04, rd); check("R1 clk reg", rd, 32'd0);
        bus_read(8'h0C, rd); check("R1 init reg", rd, 32'd0);

        // R8 writes ignored while software reset held
        bus_write(8'h00, 32'd1);
        bus_read(8'h00, rd); check("R8 readback", rd, 32'd1);
        bus_write(req_ofs(0), 32'd2);
        bus_read(req_ofs(0), rd); check("R8 req ignored", rd, 32'd0);
        bus_write(8'h00, 32'd0);

        // R6 enables
        bus_write(8'h04, clken_word(1'b1, 4'hF));
        bus_read(8'h04, rd); check("R11 clk reg", rd, 32'h0001_000F);
        check("R6 all on", 32'(agent_clk_en), 32'hF);

        // R3 exact timing, R2 readback
        timed_change(0, 2'd1, "R3 a0");
        bus_read(req_ofs(0), rd); check("R2 req a0", rd, 32'd1);
        bus_read(stat_ofs(0), rd); check("R2 stat a0", rd, 32'd1);

        // R4 agent gate mid transition, R5 disable register
        bus_write(req_ofs(1), 32'd2);
        repeat (2) @(negedge clk);
        bus_write(8'h08, 32'h2);
        check("R5 drop one", 32'(agent_clk_en), 32'hD);
        repeat (10) @(negedge clk);
        check("R4 held agent", 32'(agent_mode[3:2]), 32'd0);
        bus_read(8'h08, rd); check("R5 reads zero", rd, 32'd0);
        bus_read(8'h04, rd); check("R5 others kept", rd, 32'h0001_000D);
        bus_write(8'h04, clken_word(1'b1, 4'hF));
        repeat (4) @(negedge clk);
        check("R4 resume before", 32'(agent_mode[3:2]), 32'd0);
        @(negedge clk);
        check("R4 resume after", 32'(agent_mode[3:2]), 32'd2);
        exp_mode[1] = 2'd2;

        // R4 global gate, R6
        bus_write(8'h04, clken_word(1'b0, 4'hF));
        check("R6 global off", 32'(agent_clk_en), 32'h0);
        bus_write(req_ofs(2), 32'd3);
        repeat (20) @(negedge clk);
        check("R4 global held", 32'(agent_mode[5:4]), 32'd0);
        bus_write(8'h04, clken_word(1'b1, 4'hF));
        repeat (TRANS-1) @(negedge clk);
        check("R4 global before", 32'(agent_mode[5:4]), 32'd0);
        @(negedge clk);
        check("R4 global after", 32'(agent_mode[5:4]), 32'd3);
        exp_mode[2] = 2'd3;

        // R7 restart during transition
        bus_write(req_ofs(3), 32'd1);
        repeat (3) @(negedge clk);
        timed_change(3, 2'd2, "R7 restart");

        // R8 software reset forces all agents
        bus_write(8'h00, 32'd1);
        @(negedge clk);
        check("R8 forced", 32'(agent_mode), 32'd0);
        bus_write(8'h00, 32'd0);
        for (int i = 0; i < N; i++) exp_mode[i] = 2'd0;
        repeat (10) @(negedge clk);
        check("R8 stays reset", 32'(agent_mode), 32'd0);
        bus_read(stat_ofs(2), rd); check("R8 stat reg", rd, 32'd0);
        bus_read(8'h04, rd); check("R8 clocks kept", rd, 32'h0001_000F);
        timed_change(0, 2'd1, "R8 post disable");

        // R9 full sweep
        bus_write(8'h0C, 32'd1);
        for (int j = 0; j < DEPTH; j++) begin
            if (clr_we !== 1'b1 || clr_addr !== AW'(j))
                check("R9 sweep", {clr_we, 7'd0, 24'(clr_addr)}, {1'b1, 7'd0, 24'(j)});
            else n_checks++;
            @(negedge clk);
        end
        check("R9 strobe end", 32'(clr_we), 32'd0);
        bus_read(8'h0C, rd); check("R9 ready", rd, 32'd2);

        // R10 restart mid sweep and zero write
        bus_write(8'h0C, 32'd1);
        bus_read(8'h0C, rd); check("R9 busy", rd, 32'd1);
        repeat (8) @(negedge clk);
        bus_write(8'h0C, 32'd1);
        check("R10 restart addr", 32'(clr_addr), 32'd0);
        repeat (DEPTH) @(negedge clk);
        check("R10 done", 32'(clr_we), 32'd0);
        bus_write(8'h0C, 32'd0);
        bus_read(8'h0C, rd); check("R10 zero ignored", rd, 32'd2);

        // R11 unmapped and hold
        bus_read(8'h10, rd); check("R11 unmapped", rd, 32'd0);
        bus_read(8'h04, rd);
        repeat (3) @(negedge clk);
        check("R11 hold", bus_rdata, 32'h0001_000F);
        bus_read(8'h60, rd); check("R11 unmapped hi", rd, 32'd0);

        // random targets
        for (int k = 0; k < 40; k++) begin
            int a;
            logic [1:0] m;
            a = int'($urandom % N);
            m = 2'($urandom % 4);
            timed_change(a, m, "R3 rand");
            check("R3 others", 32'(agent_mode), 32'(packed_exp()));
            bus_read(req_ofs(a), rd); check("R2 rand req", rd, 32'(m));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule